// File: doc/BRIEF.md
# Parallel Camera Pixel Capture with Ping-Pong Word Delivery

This block sits on the pixel clock of a parallel image sensor. The sensor drives a frame qualifier, a line qualifier and an 8-bit data bus. A byte is taken only on rising pixel-clock edges where both qualifiers are high. Taken bytes are packed little-endian into 32-bit words. Each word carries three things: a valid-byte count, an end-of-line flag and an end-of-frame flag. Words go out on a valid/ready stream that is steered to one of two buffer channels, filled in turn. The stream has one shared data path, one valid per channel and one ready per channel.

The active channel changes in two cases: after a programmable number of accepted words, or after the word that closes a frame. There is no back-pressure. A word offered to a channel that is not ready is dropped, and a sticky overflow flag is set. At each frame end the block latches two counts: the number of lines that had data, and the number of bytes in the last line. The sensor's active-low reset pin is a registered copy of a control input, so the capture logic never drives it.

A word becomes complete on its fourth byte, or with fewer bytes at the end of a line. It is then held until the block knows how to flag it. It is released by the next captured byte (inside the same line, or at the start of the next line), or by the fall of the frame qualifier. Holding the word is how the last word of a line can carry end-of-line, and the last word of a frame can carry end-of-frame.

A state machine with three states tracks the qualifiers:
- IDLE: outside a frame.
- LINE: the current sample is captured.
- BLANK: inside a frame, between lines.

Its transitions are:
- frame_open: IDLE to BLANK, frame qualifier high and line qualifier low.
- line_open_direct: IDLE to LINE, both qualifiers high.
- line_open: BLANK to LINE.
- line_close: LINE to BLANK, line qualifier low and frame qualifier still high.
- frame_close: LINE or BLANK to IDLE, frame qualifier low.

The machine decodes three events:
- capture: both qualifiers high at an edge.
- line end: in LINE and not capturing.
- frame end: not in IDLE and the frame qualifier low.

Top module: `pixcap_top`

## Requirements
- R1: A data byte is captured only at a rising clock edge where `frm_act` and `row_act` are both 1. Bus values at any other edge have no effect on any word, count or flag.
- R2: Captured bytes are packed little-endian: the first byte of a group of four goes to `word_data[7:0]` and the fourth to `word_data[31:24]`. A full word reports `word_bytes` = 4.
- R3: A completed word is presented for exactly one cycle, the cycle after the edge that releases it. A word is released by the next captured byte, or by the edge at which `frm_act` is sampled low. It is never presented twice.
- R4: At a line end that leaves 1 to 3 bytes unpacked, a word is formed holding those bytes in the low lanes, with the upper bytes zero and `word_bytes` set to the byte count. The last word of every line, full or partial, has `word_eol` = 1; no other word has it.
- R5: The last word of a frame is released at the edge where `frm_act` is first sampled low, and it carries both `word_eof` = 1 and `word_eol` = 1. This holds even when `row_act` falls on the same edge.
- R6: At most one bit of `ch_valid` is high at a time. Bit 0 is channel 0. Words go to channel 0 after reset. The channel toggles in two cases: after `cfg_buf_words` words have been accepted on it (0 disables this), or after the end-of-frame word has been offered, whether or not it was accepted. The word count of a channel restarts at each toggle.
- R7: A word whose channel has `ch_ready` low in its valid cycle is dropped and not counted toward `cfg_buf_words`. `ovf_sticky` rises in the next cycle and stays 1 until reset.
- R8: From the cycle after a frame end, `stat_lines` holds the number of lines in that frame that had at least one byte, and `stat_pixels` holds the byte count of its last line. Both are 0 for a frame with no data, and both hold until the next frame end.
- R9: `sensor_rst_n` equals the inverse of `cfg_sensor_hold` delayed by one clock, and it is 0 while `rst_n` is low.
- R10: While in reset, `ch_valid` is 0, `ovf_sticky` is 0 and both status counts are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running pixel clock from the sensor; clocks the whole block |
| rst_n | input | 1 | Asynchronous active-low block reset |
| frm_act | input | 1 | Frame qualifier, high for the whole active frame |
| row_act | input | 1 | Line qualifier, high for each active line |
| pix_byte | input | 8 | Sensor data bus |
| cfg_sensor_hold | input | 1 | 1 holds the sensor in reset |
| cfg_buf_words | input | 16 | Accepted words per buffer before the channel toggles; 0 means toggle at frame end only |
| ch_ready | input | 2 | Ready from buffer channel 1 (bit 1) and channel 0 (bit 0) |
| ch_valid | output | 2 | Word valid toward channel 1 (bit 1) or channel 0 (bit 0) |
| word_data | output | 32 | Packed word, first byte in bits 7:0 |
| word_bytes | output | 3 | Number of valid bytes, 1 to 4 |
| word_eol | output | 1 | Word is the last one of its line |
| word_eof | output | 1 | Word is the last one of its frame |
| ovf_sticky | output | 1 | A word was dropped because its channel was not ready |
| sensor_rst_n | output | 1 | Active-low reset to the sensor |
| stat_lines | output | 12 | Lines with data in the last finished frame |
| stat_pixels | output | 14 | Bytes in the last line of the last finished frame |

## Verification
The assertions assume the qualifiers are synchronous to the pixel clock. They also assume a line qualifier that rises outside a frame is simply ignored, not treated as a line. The stimulus changes all inputs on the falling clock edge only, so every rising edge sees stable levels. The stimulus includes:
- lines of one byte separated by one blank cycle;
- frames whose last line ends on the same edge as the frame qualifier;
- frames with no line at all;
- line pulses with the frame qualifier low.

Readiness is either held high or toggled in a fixed pattern, so dropped words and the channel toggle they do not cause are both exercised. The buffer size changes only between frames.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int NB_W   = $clog2(LANES + 1);
    localparam int CNT_W  = $clog2(LANES);
    localparam int NCH    = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LINE  = 2'd1,
        ST_BLANK = 2'd2
    } cap_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [NB_W-1:0]   nbytes;
        logic              eol;
        logic              eof;
    } cap_word_t;
endpackage

// File: rtl/pixcap_fsm.sv
module pixcap_fsm
    import pixcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frm_act,
    input  logic row_act,
    output logic cap,
    output logic line_end,
    output logic frame_end
);
    cap_state_t st_q;
    cap_state_t st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: frame_open, line_open_direct, line_open, line_close, frame_close
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (frm_act && row_act) begin
                    st_d = ST_LINE;        // line_open_direct
                end else if (frm_act) begin
                    st_d = ST_BLANK;       // frame_open
                end
            end
            ST_LINE: begin
                if (!frm_act) begin
                    st_d = ST_IDLE;        // frame_close
                end else if (!row_act) begin
                    st_d = ST_BLANK;       // line_close
                end
            end
            ST_BLANK: begin
                if (!frm_act) begin
                    st_d = ST_IDLE;        // frame_close
                end else if (row_act) begin
                    st_d = ST_LINE;        // line_open
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // event outputs
    always_comb begin
        cap       = frm_act && row_act;
        line_end  = (st_q == ST_LINE) && !(frm_act && row_act);
        frame_end = (st_q != ST_IDLE) && !frm_act;
    end

    // R1: a capture always leaves the machine in LINE
    a_r1_cap_enters_line: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (st_q == ST_LINE));

    // R5: after a frame end the machine is outside the frame
    a_r5_frame_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (st_q == ST_IDLE));
endmodule

// File: rtl/pixcap_packer.sv
module pixcap_packer
    import pixcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] pix_byte,
    input  logic              cap,
    input  logic              line_end,
    input  logic              frame_end,
    output logic              rel_v,
    output cap_word_t         rel_w
);
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] full_w;
    logic [WORD_W-1:0] part_w;
    logic [WORD_W-1:0] pend_data_q;
    logic [NB_W-1:0]   pend_nb_q;
    logic              pend_eol_q;
    logic              pend_v_q;
    logic              part_close;
    logic              last_lane;

    assign last_lane = (cnt_q == CNT_W'(LANES - 1));

    // one holding register per lower lane
    for (genvar i = 0; i < LANES - 1; i++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (cap && (int'(cnt_q) == i)) begin
                lane_q <= pix_byte;
            end
        end
        assign full_w[i*BYTE_W +: BYTE_W] = lane_q;
        assign part_w[i*BYTE_W +: BYTE_W] = (int'(cnt_q) > i) ? lane_q : '0;
    end
    assign full_w[(LANES-1)*BYTE_W +: BYTE_W] = pix_byte;
    assign part_w[(LANES-1)*BYTE_W +: BYTE_W] = '0;

    // release: next byte, or frame end (partial formed on the same edge)
    always_comb begin
        part_close   = frame_end && line_end && (cnt_q != '0);
        rel_v        = part_close || (pend_v_q && (cap || frame_end));
        rel_w.data   = part_close ? part_w : pend_data_q;
        rel_w.nbytes = part_close ? NB_W'(cnt_q) : pend_nb_q;
        rel_w.eol    = frame_end ? 1'b1 : pend_eol_q;
        rel_w.eof    = frame_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            pend_data_q <= '0;
            pend_nb_q   <= '0;
            pend_eol_q  <= 1'b0;
            pend_v_q    <= 1'b0;
        end else begin
            if (cap) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (line_end) begin
                cnt_q <= '0;
            end

            if (cap && last_lane) begin
                pend_data_q <= full_w;
                pend_nb_q   <= NB_W'(LANES);
                pend_eol_q  <= 1'b0;
                pend_v_q    <= 1'b1;
            end else if (line_end && !frame_end && (cnt_q != '0)) begin
                pend_data_q <= part_w;
                pend_nb_q   <= NB_W'(cnt_q);
                pend_eol_q  <= 1'b1;
                pend_v_q    <= 1'b1;
            end else if (rel_v) begin
                pend_v_q    <= 1'b0;
            end else if (line_end && !frame_end) begin
                pend_eol_q  <= 1'b1;
            end
        end
    end

    // R3: the holding register is always free when a word completes
    a_r3_pend_free: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && last_lane) |-> !pend_v_q);

    // R4: a short word is always the last word of a line
    a_r4_short_is_eol: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_v && (rel_w.nbytes != NB_W'(LANES))) |-> rel_w.eol);

    // R4: byte count stays in range
    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        rel_v |-> ((rel_w.nbytes != '0) && (rel_w.nbytes <= NB_W'(LANES))));
endmodule

// File: rtl/pixcap_router.sv
module pixcap_router
    import pixcap_pkg::*;
#(
    parameter int BUF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rel_v,
    input  cap_word_t        rel_w,
    input  logic [BUF_W-1:0] cfg_buf_words,
    input  logic [NCH-1:0]   ch_ready,
    output logic [NCH-1:0]   ch_valid,
    output cap_word_t        out_w,
    output logic             ovf_sticky
);
    logic             out_v_q;
    logic             out_chan_q;
    logic             chan_q;
    logic             chan_eff;
    logic [BUF_W-1:0] bw_q;
    logic             acc_now;
    logic             full_now;
    logic             sw;

    always_comb begin
        acc_now  = ch_ready[out_chan_q];
        full_now = (cfg_buf_words != '0) && ((bw_q + 1'b1) == cfg_buf_words);
        sw       = out_v_q && (out_w.eof || (acc_now && full_now));
        chan_eff = sw ? ~chan_q : chan_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_v_q    <= 1'b0;
            out_chan_q <= 1'b0;
            out_w      <= '0;
            chan_q     <= 1'b0;
            bw_q       <= '0;
            ovf_sticky <= 1'b0;
        end else begin
            chan_q <= chan_eff;
            if (sw) begin
                bw_q <= '0;
            end else if (out_v_q && acc_now) begin
                bw_q <= bw_q + 1'b1;
            end
            if (out_v_q && !acc_now) begin
                ovf_sticky <= 1'b1;
            end
            out_v_q    <= rel_v;
            out_chan_q <= chan_eff;
            if (rel_v) begin
                out_w <= rel_w;
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign ch_valid[c] = out_v_q && (out_chan_q == 1'(c));
    end

    // R6: never two channels at once
    a_r6_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_valid));

    // R6: the frame-closing word moves the next words to the other channel
    a_r6_eof_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (out_v_q && out_w.eof) |=> (chan_q != $past(chan_q)));

    // R7: overflow never clears outside reset
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky);

    // R7: a refused word raises overflow
    a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (out_v_q && !acc_now) |=> ovf_sticky);

    // R5: end of frame is always also end of line
    a_r5_eof_eol: assert property (@(posedge clk) disable iff (!rst_n)
        (out_v_q && out_w.eof) |-> out_w.eol);
endmodule

// File: rtl/pixcap_stats.sv
module pixcap_stats #(
    parameter int LINE_W = 12,
    parameter int PIX_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              line_end,
    input  logic              frame_end,
    output logic [LINE_W-1:0] stat_lines,
    output logic [PIX_W-1:0]  stat_pixels
);
    logic [LINE_W-1:0] line_cnt_q;
    logic [PIX_W-1:0]  pix_run_q;
    logic [PIX_W-1:0]  last_pix_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_cnt_q  <= '0;
            pix_run_q   <= '0;
            last_pix_q  <= '0;
            stat_lines  <= '0;
            stat_pixels <= '0;
        end else begin
            if (cap) begin
                pix_run_q <= pix_run_q + 1'b1;
            end else if (line_end) begin
                pix_run_q <= '0;
            end

            if (frame_end) begin
                stat_lines  <= line_cnt_q + {{(LINE_W-1){1'b0}}, line_end};
                stat_pixels <= line_end ? pix_run_q : last_pix_q;
                line_cnt_q  <= '0;
                last_pix_q  <= '0;
            end else if (line_end) begin
                line_cnt_q  <= line_cnt_q + 1'b1;
                last_pix_q  <= pix_run_q;
            end
        end
    end

    // R8: status only changes at a frame end
    a_r8_stats_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(stat_lines) && $stable(stat_pixels)));
endmodule

// File: rtl/pixcap_top.sv
module pixcap_top
    import pixcap_pkg::*;
#(
    parameter int BUF_W  = 16,
    parameter int LINE_W = 12,
    parameter int PIX_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_act,
    input  logic              row_act,
    input  logic [BYTE_W-1:0] pix_byte,
    input  logic              cfg_sensor_hold,
    input  logic [BUF_W-1:0]  cfg_buf_words,
    input  logic [NCH-1:0]    ch_ready,
    output logic [NCH-1:0]    ch_valid,
    output logic [WORD_W-1:0] word_data,
    output logic [NB_W-1:0]   word_bytes,
    output logic              word_eol,
    output logic              word_eof,
    output logic              ovf_sticky,
    output logic              sensor_rst_n,
    output logic [LINE_W-1:0] stat_lines,
    output logic [PIX_W-1:0]  stat_pixels
);
    logic      cap;
    logic      line_end;
    logic      frame_end;
    logic      rel_v;
    cap_word_t rel_w;
    cap_word_t out_w;
    logic      hold_q;

    pixcap_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_act   (frm_act),
        .row_act   (row_act),
        .cap       (cap),
        .line_end  (line_end),
        .frame_end (frame_end)
    );

    pixcap_packer u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_byte  (pix_byte),
        .cap       (cap),
        .line_end  (line_end),
        .frame_end (frame_end),
        .rel_v     (rel_v),
        .rel_w     (rel_w)
    );

    pixcap_router #(.BUF_W(BUF_W)) u_router (
        .clk           (clk),
        .rst_n         (rst_n),
        .rel_v         (rel_v),
        .rel_w         (rel_w),
        .cfg_buf_words (cfg_buf_words),
        .ch_ready      (ch_ready),
        .ch_valid      (ch_valid),
        .out_w         (out_w),
        .ovf_sticky    (ovf_sticky)
    );

    pixcap_stats #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_stats (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap         (cap),
        .line_end    (line_end),
        .frame_end   (frame_end),
        .stat_lines  (stat_lines),
        .stat_pixels (stat_pixels)
    );

    // sensor reset follows its control register only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b1;
        end else begin
            hold_q <= cfg_sensor_hold;
        end
    end

    assign sensor_rst_n = ~hold_q;
    assign word_data    = out_w.data;
    assign word_bytes   = out_w.nbytes;
    assign word_eol     = out_w.eol;
    assign word_eof     = out_w.eof;

    // R9: sensor reset tracks the control input one cycle later
    a_r9_sensor_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sensor_rst_n == !$past(cfg_sensor_hold)));
endmodule

// File: tb/test_pixcap_top.sv
module test_pixcap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_act = 1'b0;
    logic        row_act = 1'b0;
    logic [7:0]  pix_byte = 8'h00;
    logic        cfg_sensor_hold = 1'b1;
    logic [15:0] cfg_buf_words = 16'd0;
    logic [1:0]  ch_ready = 2'b11;
    logic [1:0]  ch_valid;
    logic [31:0] word_data;
    logic [2:0]  word_bytes;
    logic        word_eol;
    logic        word_eof;
    logic        ovf_sticky;
    logic        sensor_rst_n;
    logic [11:0] stat_lines;
    logic [13:0] stat_pixels;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int ready_mode = 0;
    logic [7:0] next_byte = 8'h10;
    bit   checking = 1'b0;

    always #4 clk = ~clk;

    pixcap_top i_pixcap_top (
        .clk(clk), .rst_n(rst_n), .frm_act(frm_act), .row_act(row_act),
        .pix_byte(pix_byte), .cfg_sensor_hold(cfg_sensor_hold),
        .cfg_buf_words(cfg_buf_words), .ch_ready(ch_ready), .ch_valid(ch_valid),
        .word_data(word_data), .word_bytes(word_bytes), .word_eol(word_eol),
        .word_eof(word_eof), .ovf_sticky(ovf_sticky), .sensor_rst_n(sensor_rst_n),
        .stat_lines(stat_lines), .stat_pixels(stat_pixels)
    );

    // behavioural reference model
    logic [7:0] cur[$];
    bit         held_v, held_eol;
    int         held_nb;
    logic [31:0] held_data;
    bit         e_valid, e_chan, e_eol, e_eof, e_ovf, e_srst_n;
    int         e_nb;
    logic [31:0] e_data;
    int         e_lines, e_pix, lines, pix, lastpix, bw;
    bit         chan, in_line, in_frame;

    function automatic logic [31:0] pack_q();
        logic [31:0] w = '0;
        foreach (cur[i]) w[i*8 +: 8] = cur[i];
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cur.delete(); held_v = 0; held_eol = 0; held_nb = 0; held_data = '0;
            e_valid = 0; e_chan = 0; e_eol = 0; e_eof = 0; e_ovf = 0; e_srst_n = 0;
            e_nb = 0; e_data = '0; e_lines = 0; e_pix = 0; lines = 0; pix = 0;
            lastpix = 0; bw = 0; chan = 0; in_line = 0; in_frame = 0;
        end else begin
            bit acc, s, le, fe, nv;
            if (e_valid) begin
                acc = ch_ready[e_chan];
                if (!acc) e_ovf = 1;
                if (e_eof || (acc && cfg_buf_words != 0 && bw + 1 == int'(cfg_buf_words))) begin
                    chan = ~chan; bw = 0;
                end else if (acc) bw++;
            end
            nv = 0;
            s  = frm_act && row_act;
            le = in_line && !s;
            fe = in_frame && !frm_act;
            if (s) begin
                if (held_v) begin
                    nv = 1; e_data = held_data; e_nb = held_nb; e_eol = held_eol; e_eof = 0;
                    held_v = 0;
                end
                cur.push_back(pix_byte); pix++;
                if (cur.size() == 4) begin
                    held_data = pack_q(); held_nb = 4; held_eol = 0; held_v = 1; cur.delete();
                end
            end
            if (le) begin
                lines++; lastpix = pix; pix = 0;
                if (cur.size() > 0) begin
                    held_data = pack_q(); held_nb = cur.size(); held_eol = 1; held_v = 1; cur.delete();
                end else if (held_v) held_eol = 1;
            end
            if (fe) begin
                e_lines = lines; e_pix = lastpix; lines = 0; lastpix = 0;
                if (held_v) begin
                    nv = 1; e_data = held_data; e_nb = held_nb; e_eol = 1; e_eof = 1;
                    held_v = 0;
                end
            end
            in_line = s; in_frame = frm_act;
            e_valid = nv; e_chan = chan;
            e_srst_n = !cfg_sensor_hold;
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (checking && rst_n) begin
            logic [1:0] ev;
            ev = e_valid ? (2'b01 << e_chan) : 2'b00;
            chk(ch_valid == ev, "R1 R3 R6 ch_valid", ch_valid, ev);
            if (e_valid) begin
                chk(word_data == e_data, "R1 R2 word_data", word_data, e_data);
                chk(int'(word_bytes) == e_nb, "R2 R4 word_bytes", word_bytes, e_nb);
                chk(word_eol == e_eol, "R4 word_eol", word_eol, e_eol);
                chk(word_eof == e_eof, "R5 word_eof", word_eof, e_eof);
            end
            chk(ovf_sticky == e_ovf, "R7 ovf_sticky", ovf_sticky, e_ovf);
            chk(int'(stat_lines) == e_lines, "R8 stat_lines", stat_lines, e_lines);
            chk(int'(stat_pixels) == e_pix, "R8 stat_pixels", stat_pixels, e_pix);
            chk(sensor_rst_n == e_srst_n, "R9 sensor_rst_n", sensor_rst_n, e_srst_n);
        end
    end

    // readiness pattern, driven on the falling edge
    always @(negedge clk) begin
        if (ready_mode == 0) ch_ready <= 2'b11;
        else ch_ready <= {cyc[1], cyc[0] ^ cyc[2]};
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // frame: nlines lines, line l has base+l*step bytes, hgap blank cycles
    task automatic send_frame(input int nlines, input int base, input int step,
                              input int hgap, input bit end_with_row);
        @(negedge clk); frm_act = 1; row_act = 0;
        @(negedge clk);
        for (int l = 0; l < nlines; l++) begin
            for (int b = 0; b < base + l * step; b++) begin
                row_act = 1; pix_byte = next_byte; next_byte = next_byte + 8'd7;
                @(negedge clk);
            end
            if (l == nlines - 1 && end_with_row) begin
                row_act = 0; frm_act = 0;
            end else begin
                row_act = 0; pix_byte = 8'hEE;
                idle(hgap);
            end
        end
        frm_act = 0; row_act = 0;
        idle(3);
        // line pulses outside a frame must be ignored (R1)
        row_act = 1; pix_byte = 8'hA5; idle(3);
        row_act = 0; idle(3);
    endtask

    initial begin
        idle(3);
        // R10 reset state
        tests++; if (ch_valid !== 2'b00) begin fails++; $display("FAIL R10 ch_valid actual=%0h expected=0", ch_valid); end
        tests++; if (ovf_sticky !== 1'b0) begin fails++; $display("FAIL R10 ovf actual=%0h expected=0", ovf_sticky); end
        tests++; if (stat_lines !== 12'd0 || stat_pixels !== 14'd0) begin fails++; $display("FAIL R10 stats actual=%0h/%0h expected=0/0", stat_lines, stat_pixels); end
        tests++; if (sensor_rst_n !== 1'b0) begin fails++; $display("FAIL R9 sensor_rst_n in reset actual=%0h expected=0", sensor_rst_n); end
        rst_n = 1; checking = 1;
        idle(2);
        cfg_sensor_hold = 0; idle(3);
        // R1: qualifier pulses with frame low
        row_act = 1; pix_byte = 8'h33; idle(4); row_act = 0; idle(2);
        // R2/R4: full-word lines, toggle only at frame end
        cfg_buf_words = 16'd0;
        send_frame(3, 8, 0, 2, 0);
        // R4: partial words, count-based toggle
        cfg_buf_words = 16'd2;
        send_frame(3, 5, 1, 1, 0);
        // R5: one-byte lines, frame and line close together
        cfg_buf_words = 16'd3;
        send_frame(4, 1, 0, 1, 1);
        // R8: frame with no data
        send_frame(0, 0, 0, 1, 0);
        // R7: refused words
        cfg_sensor_hold = 1;
        ready_mode = 1; cfg_buf_words = 16'd1;
        send_frame(3, 9, 3, 2, 1);
        ready_mode = 0; cfg_sensor_hold = 0;
        // R6: long buffers, ovf stays set
        cfg_buf_words = 16'd4;
        send_frame(2, 4, 0, 3, 0);
        send_frame(2, 12, 2, 1, 1);
        idle(5);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule